// File: doc/BRIEF.md
# Fixed-Address I2C Memory Slave

This block is the serial protocol engine for a 128-byte memory in its bidirectional mode. It takes SCL and SDA after they have been synchronized to the system clock. It produces one output, an enable that pulls SDA low. The engine recognizes bus Start and Stop conditions and answers one hard-wired 7-bit device address. After a write control byte, it loads the next byte as the word address. It then hands every later data byte to a separate write controller as a one-cycle strobe that carries the address and the data.

For reads, the engine keeps a single shared address pointer. It presents that pointer to the memory and serializes the returned byte MSB first. This supports three kinds of read:
- current-address reads;
- random reads, where a word-address write is followed by a repeated Start;
- sequential reads, which the master keeps going by acknowledging each byte.

While the write controller reports a busy write cycle, the engine acknowledges nothing. A master can therefore poll with control bytes until the cycle finishes. The SDA pull enable only changes a fixed number of system clocks after SCL falls. This prevents the slave from creating a false Start or Stop.

Top module: `i2c_mem_slave`

## Requirements
- R1: A control byte whose upper seven bits are 1010000 is acknowledged, with bit 0 selecting read (1) or write (0). Any other control byte gets no acknowledge, and every byte after it is ignored until the next Start.
- R2: After reset, or after a Stop, SDA is released, no write strobe is issued and the engine is idle. A Stop (SDA rising while SCL is high) produces a one-cycle `stop_o` pulse. A Start (SDA falling while SCL is high) in any state restarts control-byte reception.
- R3: An acknowledge pulls SDA low exactly HOLD_CYC+1 system clocks after the falling SCL edge that ends the eighth bit. The engine releases SDA the same delay after the falling edge that ends the ninth clock.
- R4: While `wr_busy_i` is high at the falling edge that ends a received byte, no acknowledge is given to that byte. This applies to control bytes and to word-address bytes. The engine then ignores the bus until the next Start.
- R5: After an acknowledged write control byte, the next byte is loaded into the address pointer. Only its low 7 bits are kept, so bit 7 has no effect.
- R6: Each following data byte is acknowledged and produces one `wr_valid_o` pulse with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte. After the pulse, only the low 3 pointer bits advance, so a burst wraps inside its 8-byte page.
- R7: A read sends the byte at the pointer on SDA, MSB first, one bit per SCL clock. A current-address read returns the byte one past the last byte accessed.
- R8: A repeated Start after the word address ends the write without a data strobe and leaves the pointer loaded for the following read.
- R9: During a read, a master acknowledge (SDA low on the ninth clock) makes the engine send the next byte. A master non-acknowledge makes it release SDA and go idle.
- R10: The pointer advances by one over its full 7 bits after every byte sent, wrapping from 127 to 0.
- R11: The SDA pull enable only turns on while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data |
| wr_busy_i | input | 1 | Write controller is in a write cycle |
| rd_data_i | input | 8 | Memory byte at `ptr_o` |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| ptr_o | output | 7 | Address pointer, used as the read address |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 7 | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| stop_o | output | 1 | One-cycle pulse on a Stop condition |

## Verification
The busy flag and the end-of-byte decision can meet in one system clock. In that case the acknowledge decision must use the busy value of that exact cycle. The bench provokes this by raising `wr_busy_i` at the same clock edge where it lowers SCL after the eighth bit of a control byte. On the ninth clock it expects SDA to stay high, and it expects the next polling attempt after busy falls to be acknowledged. The bench also times the acknowledge onset and release to the exact system clock, and walks the pointer through page wrap, read wrap at 127 and a repeated Start in the middle of a byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADR,
        ST_ADR_ACK,
        ST_DAT,
        ST_DAT_ACK,
        ST_RD,
        ST_RD_ACK
    } i2cs_state_e;

endpackage

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t prev_q, prev_d;

    always_comb begin
        prev_d.scl = scl_i;
        prev_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    // Start and Stop both need SCL high on both samples
    assign start_o = scl_i & prev_q.scl & prev_q.sda & ~sda_i;
    assign stop_o  = scl_i & prev_q.scl & ~prev_q.sda & sda_i;
    assign rise_o  = scl_i & ~prev_q.scl;
    assign fall_o  = ~scl_i & prev_q.scl;

endmodule

// File: rtl/i2cs_hold_drive.sv
module i2cs_hold_drive #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pull_o
);

    localparam int HW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic          out;
        logic [HW-1:0] cnt;
    } drv_t;

    drv_t q, d;

    always_comb begin
        d = q;
        if (req_i == q.out) begin
            d.cnt = '0;
        end else if (q.cnt == HW'(HOLD_CYC - 1)) begin
            d.out = req_i;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + HW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pull_o = q.out;

    // R3: the output only ever takes a value the request held one cycle earlier
    assert_hold_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_o != $past(pull_o)) |-> ($past(req_i) == pull_o));

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
    parameter int         AW        = 7,
    parameter int         PAGE_BITS = 3,
    parameter logic [6:0] DEV_ADDR  = 7'b1010000,
    parameter int         HOLD_CYC  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          wr_busy_i,
    input  logic [7:0]    rd_data_i,
    output logic          sda_pull_o,
    output logic [AW-1:0] ptr_o,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          stop_o
);
    import i2cs_pkg::*;

    localparam int            BW    = 8;
    localparam int            CW    = $clog2(BW + 1);
    localparam logic [AW-1:0] PMASK = AW'((1 << PAGE_BITS) - 1);

    typedef struct packed {
        i2cs_state_e   st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] sh;
        logic [BW-1:0] tx;
        logic [AW-1:0] ptr;
        logic          mack;
        logic          wv;
        logic [AW-1:0] wa;
        logic [BW-1:0] wd;
        logic          stp;
    } core_t;

    core_t r_q, r_d;
    logic  ev_start, ev_stop, ev_rise, ev_fall, pull_req;
    logic  rx_state, byte_done;

    i2cs_bus_events i_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall)
    );

    assign rx_state  = (r_q.st == ST_DEV) || (r_q.st == ST_ADR) || (r_q.st == ST_DAT);
    assign byte_done = ev_fall && (r_q.cnt == CW'(BW));

    always_comb begin
        r_d     = r_q;
        r_d.wv  = 1'b0;
        r_d.stp = 1'b0;
        if (ev_stop) begin
            r_d.st  = ST_IDLE;
            r_d.stp = 1'b1;
        end else if (ev_start) begin
            r_d.st  = ST_DEV;
            r_d.cnt = '0;
        end else if (rx_state) begin
            if (ev_rise) begin
                r_d.sh  = {r_q.sh[BW-2:0], sda_i};
                r_d.cnt = r_q.cnt + CW'(1);
            end else if (byte_done) begin
                r_d.cnt = '0;
                if (wr_busy_i) begin
                    r_d.st = ST_IDLE;
                end else if (r_q.st == ST_DEV) begin
                    r_d.st = (r_q.sh[BW-1:1] == DEV_ADDR) ? ST_DEV_ACK : ST_IDLE;
                end else if (r_q.st == ST_ADR) begin
                    r_d.ptr = r_q.sh[AW-1:0];
                    r_d.st  = ST_ADR_ACK;
                end else begin
                    r_d.wv  = 1'b1;
                    r_d.wa  = r_q.ptr;
                    r_d.wd  = r_q.sh;
                    r_d.ptr = (r_q.ptr & ~PMASK) | ((r_q.ptr + AW'(1)) & PMASK);
                    r_d.st  = ST_DAT_ACK;
                end
            end
        end else begin
            unique case (r_q.st)
                ST_DEV_ACK: if (ev_fall) begin
                    if (r_q.sh[0]) begin
                        r_d.st = ST_RD;
                        r_d.tx = rd_data_i;
                    end else begin
                        r_d.st = ST_ADR;
                    end
                end
                ST_ADR_ACK, ST_DAT_ACK: if (ev_fall) r_d.st = ST_DAT;
                ST_RD: begin
                    if (ev_rise) begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end else if (byte_done) begin
                        r_d.st  = ST_RD_ACK;
                        r_d.cnt = '0;
                        r_d.ptr = r_q.ptr + AW'(1);
                    end else if (ev_fall) begin
                        r_d.tx = {r_q.tx[BW-2:0], 1'b0};
                    end
                end
                ST_RD_ACK: begin
                    if (ev_rise) begin
                        r_d.mack = ~sda_i;
                    end else if (ev_fall) begin
                        if (r_q.mack) begin
                            r_d.st = ST_RD;
                            r_d.tx = rd_data_i;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign pull_req = (r_q.st == ST_DEV_ACK) || (r_q.st == ST_ADR_ACK) ||
                      (r_q.st == ST_DAT_ACK) || ((r_q.st == ST_RD) && !r_q.tx[BW-1]);

    i2cs_hold_drive #(.HOLD_CYC(HOLD_CYC)) i_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (pull_req),
        .pull_o (sda_pull_o)
    );

    assign ptr_o      = r_q.ptr;
    assign wr_valid_o = r_q.wv;
    assign wr_addr_o  = r_q.wa;
    assign wr_data_o  = r_q.wd;
    assign stop_o     = r_q.stp;

    assert_start_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_stop) |=> (r_q.st == ST_DEV && r_q.cnt == '0));

    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (r_q.st == ST_IDLE && stop_o));

    assert_busy_noack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state && byte_done && wr_busy_i && !ev_start && !ev_stop) |=> (r_q.st == ST_IDLE));

    assert_strobe_in_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> ((r_q.ptr & ~PMASK) == (wr_addr_o & ~PMASK)));

    assert_pull_low_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);

endmodule

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 16;
    localparam int HOLD       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       wr_busy = 1'b0;
    logic [7:0] rd_data;
    logic       sda_pull;
    logic [6:0] ptr;
    logic       wr_valid;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;
    logic       stop_p;
    logic       bus_sda;

    logic [7:0] mem     [128];
    logic [7:0] exp_mem [128];
    logic [6:0] q_addr[$];
    logic [7:0] q_data[$];

    int  n_chk = 0;
    int  n_fail = 0;
    int  stop_cnt = 0;
    int  r11_bad = 0;
    bit  done = 0;
    logic scl_at_edge = 1'b1;
    logic pp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_sda = m_sda & ~sda_pull;
    assign rd_data = mem[ptr];

    i2c_mem_slave #(.HOLD_CYC(HOLD)) i_i2c_mem_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (bus_sda),
        .wr_busy_i  (wr_busy),
        .rd_data_i  (rd_data),
        .sda_pull_o (sda_pull),
        .ptr_o      (ptr),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .stop_o     (stop_p)
    );

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
    end

    always @(posedge clk) scl_at_edge = m_scl;

    // per-clock monitor: strobes, stop pulses, R11 pull onset
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                q_addr.push_back(wr_addr);
                q_data.push_back(wr_data);
                mem[wr_addr] = wr_data;
            end
            if (stop_p) stop_cnt++;
            if (sda_pull && !pp && scl_at_edge) r11_bad++;
        end
        pp = sda_pull;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_tx(input logic b, output logic seen);
        m_sda = b;
        wait_cyc(HALF);
        m_scl = 1'b1;
        wait_cyc(HALF/2);
        seen = bus_sda;
        wait_cyc(HALF - HALF/2);
        m_scl = 1'b0;
    endtask

    task automatic do_start();
        m_sda = 1'b1;
        wait_cyc(HALF);
        m_scl = 1'b1;
        wait_cyc(HALF);
        m_sda = 1'b0;
        wait_cyc(HALF);
        m_scl = 1'b0;
    endtask

    task automatic do_stop();
        m_sda = 1'b0;
        wait_cyc(HALF);
        m_scl = 1'b1;
        wait_cyc(HALF);
        m_sda = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic byte_tx(input logic [7:0] d, input bit busy_last, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_tx(d[i], s);
            if (i == 0 && busy_last) wr_busy = 1'b1;
        end
        bit_tx(1'b1, s);
        acked = !s;
    endtask

    task automatic byte_rx(input bit mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_tx(1'b1, s);
            d[i] = s;
        end
        bit_tx(mack ? 1'b0 : 1'b1, s);
    endtask

    task automatic expect_wr(input logic [6:0] a, input logic [7:0] v, input string req);
        if (q_addr.size() == 0) begin
            chk(0, req, 0, a);
        end else begin
            logic [6:0] ga;
            logic [7:0] gd;
            ga = q_addr.pop_front();
            gd = q_data.pop_front();
            chk(ga == a, req, ga, a);
            chk(gd == v, req, gd, v);
            exp_mem[a] = v;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic       s;
        logic [7:0] d;
        int         sc;

        wait_cyc(5);
        chk(sda_pull == 1'b0, "R2 reset release", sda_pull, 0);
        chk(wr_valid == 1'b0, "R2 reset strobe", wr_valid, 0);
        rst_n = 1'b1;
        wait_cyc(5);

        // R3 acknowledge timing on a matching control byte
        sc = stop_cnt;
        do_start();
        for (int i = 7; i >= 0; i--) bit_tx(((8'hA0 >> i) & 8'h1) != 0, s);
        wait_cyc(HOLD);
        chk(sda_pull == 1'b0, "R3 onset early", sda_pull, 0);
        wait_cyc(1);
        chk(sda_pull == 1'b1, "R3 onset", sda_pull, 1);
        bit_tx(1'b1, s);
        chk(s == 1'b0, "R1 control ack", s, 0);
        wait_cyc(HOLD);
        chk(sda_pull == 1'b1, "R3 release early", sda_pull, 1);
        wait_cyc(1);
        chk(sda_pull == 1'b0, "R3 release", sda_pull, 0);
        byte_tx(8'h10, 0, ack);
        chk(ack, "R5 word address ack", ack, 1);
        byte_tx(8'h11, 0, ack);
        chk(ack, "R6 data ack", ack, 1);
        byte_tx(8'h22, 0, ack);
        do_stop();
        expect_wr(7'h10, 8'h11, "R6 byte0");
        expect_wr(7'h11, 8'h22, "R6 byte1");
        chk(stop_cnt == sc + 1, "R2 stop pulse", stop_cnt - sc, 1);

        // R6 page wrap
        do_start();
        byte_tx(8'hA0, 0, ack);
        byte_tx(8'h1E, 0, ack);
        byte_tx(8'hAA, 0, ack);
        byte_tx(8'hBB, 0, ack);
        byte_tx(8'hCC, 0, ack);
        do_stop();
        expect_wr(7'h1E, 8'hAA, "R6 page");
        expect_wr(7'h1F, 8'hBB, "R6 page");
        expect_wr(7'h18, 8'hCC, "R6 page wrap");

        // R7 current-address read: last write was 0x18, so 0x19
        do_start();
        byte_tx(8'hA1, 0, ack);
        chk(ack, "R1 read control ack", ack, 1);
        byte_rx(0, d);
        chk(d == exp_mem[7'h19], "R7 current read", d, exp_mem[7'h19]);
        do_stop();

        // R8 random read at 0x7F, R9/R10 sequential with wrap
        do_start();
        byte_tx(8'hA0, 0, ack);
        byte_tx(8'h7F, 0, ack);
        do_start();
        byte_tx(8'hA1, 0, ack);
        byte_rx(1, d);
        chk(d == exp_mem[7'h7F], "R8 random read", d, exp_mem[7'h7F]);
        byte_rx(1, d);
        chk(d == exp_mem[7'h00], "R10 wrap read", d, exp_mem[7'h00]);
        byte_rx(0, d);
        chk(d == exp_mem[7'h01], "R9 sequential read", d, exp_mem[7'h01]);
        wait_cyc(HALF);
        chk(sda_pull == 1'b0, "R9 release after nack", sda_pull, 0);
        do_stop();
        chk(q_addr.size() == 0, "R8 no strobe", q_addr.size(), 0);

        do_start();
        byte_tx(8'hA1, 0, ack);
        byte_rx(0, d);
        chk(d == exp_mem[7'h02], "R10 pointer after reads", d, exp_mem[7'h02]);
        do_stop();

        // R1 wrong address ignored
        do_start();
        byte_tx(8'hA2, 0, ack);
        chk(!ack, "R1 foreign address", ack, 0);
        byte_tx(8'h33, 0, ack);
        chk(!ack, "R1 ignored byte", ack, 0);
        do_stop();
        chk(q_addr.size() == 0, "R1 no strobe", q_addr.size(), 0);

        // R4 busy polling
        wr_busy = 1'b1;
        do_start();
        byte_tx(8'hA0, 0, ack);
        chk(!ack, "R4 busy control", ack, 0);
        do_stop();
        wr_busy = 1'b0;
        do_start();
        byte_tx(8'hA0, 1, ack);
        chk(!ack, "R4 busy same cycle", ack, 0);
        do_stop();
        wr_busy = 1'b0;
        do_start();
        byte_tx(8'hA0, 0, ack);
        chk(ack, "R4 ack after busy", ack, 1);
        wr_busy = 1'b1;
        byte_tx(8'h20, 0, ack);
        chk(!ack, "R4 busy word address", ack, 0);
        do_stop();
        wr_busy = 1'b0;

        // R5 bit 7 of word address ignored
        do_start();
        byte_tx(8'hA0, 0, ack);
        byte_tx(8'h85, 0, ack);
        do_start();
        byte_tx(8'hA1, 0, ack);
        byte_rx(0, d);
        chk(d == exp_mem[7'h05], "R5 address bit7", d, exp_mem[7'h05]);
        do_stop();

        // R2 repeated start in the middle of a data byte
        do_start();
        byte_tx(8'hA0, 0, ack);
        byte_tx(8'h40, 0, ack);
        for (int i = 0; i < 4; i++) bit_tx(1'b0, s);
        do_start();
        byte_tx(8'hA1, 0, ack);
        chk(ack, "R2 restart control ack", ack, 1);
        byte_rx(0, d);
        chk(d == exp_mem[7'h40], "R2 restart read", d, exp_mem[7'h40]);
        do_stop();
        chk(q_addr.size() == 0, "R2 aborted byte no strobe", q_addr.size(), 0);

        chk(r11_bad == 0, "R11 pull onset with SCL high", r11_bad, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule